// File: doc/BRIEF.md
# Branch Class Direction Predictor

This block sits in the decode stage and guesses, for each decoded branch, whether the branch will be taken. The guess depends on the kind of branch being decoded. Unconditional jumps, subroutine calls, register-indirect jumps, system-call traps and loop-closing branches are always guessed taken. Reserved codes are guessed not taken. General conditional branches follow a policy chosen by a 2-bit mode input. The policy can be an always-not-taken bias, the compiler's hint bit, the sign of the displacement (backward taken, forward not taken), or a direction supplied by an external dynamic predictor. If-then-else decision branches take the external dynamic direction whenever it is marked valid, and fall back to the mode policy when it is not.

The guess is registered and appears one cycle after the request strobe. It is then held until the next request. When the pipeline later reports the real outcome on the resolve port, the block compares that outcome with the held guess. It then bumps one of two saturating counters, one for hits and one for misses. Target address computation and the storage of history are outside this block.

Top module: `brclass_pred`

## Requirements
- R1: While `rst` is high at a clock edge, `pred_valid`, `pred_taken`, `hit_count` and `miss_count` all become 0 at that edge.
- R2: Class codes 0 (jump), 1 (call), 2 (indirect jump), 3 (system trap) and 4 (loop) are predicted taken, whatever the mode, hint, sign and dynamic inputs are.
- R3: For class 6 (conditional), mode 0 predicts not taken.
- R4: For class 6, mode 1 predicts the value of `req_hint` (1 means taken).
- R5: For class 6, mode 2 predicts taken when `req_disp_neg` is 1 (a backward displacement) and not taken when it is 0.
- R6: For class 6, mode 3 predicts `dyn_taken` when `dyn_valid` is 1, and not taken otherwise.
- R7: For class 5 (decision), the prediction is `dyn_taken` when `dyn_valid` is 1 in any mode. When `dyn_valid` is 0, the prediction follows the class 6 rule for the current mode.
- R8: Class code 7 is predicted not taken.
- R9: `pred_valid` equals the value `req_valid` had at the previous clock edge. `pred_taken` is updated only at edges where `req_valid` is 1, and otherwise keeps its value.
- R10: At an edge where `res_valid` is 1, `hit_count` increments by one if `res_taken` equals the current `pred_taken`, and `miss_count` increments by one otherwise. Neither counter changes at edges where `res_valid` is 0.
- R11: A counter that holds its all-ones value stays there on further increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Conditional policy: 0 not taken, 1 hint, 2 displacement sign, 3 dynamic |
| req_valid | input | 1 | A branch is presented this cycle |
| req_class | input | 3 | Branch class code |
| req_hint | input | 1 | Compiler hint bit, 1 = taken |
| req_disp_neg | input | 1 | Displacement sign, 1 = backward |
| dyn_valid | input | 1 | External dynamic direction is usable |
| dyn_taken | input | 1 | External dynamic direction |
| pred_valid | output | 1 | Registered prediction strobe |
| pred_taken | output | 1 | Registered (held) prediction |
| res_valid | input | 1 | An outcome is reported this cycle |
| res_taken | input | 1 | Actual branch outcome |
| hit_count | output | CNT_W | Saturating count of correct predictions |
| miss_count | output | CNT_W | Saturating count of wrong predictions |

## Verification
The hardest state to reach is a saturated counter that keeps receiving increments. This needs many resolve reports that all land on the same side of the comparison. The bench builds the block with a narrow counter width, resets it so the held guess is known to be not taken, and then streams matching outcomes well past the limit. A second subtle case is a resolve that arrives in the same cycle as a new request. The bench's random mix produces many such cycles, and its model compares against the guess held before the edge.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int CLS_W  = 3;
  localparam int MODE_W = 2;

  typedef enum logic [CLS_W-1:0] {
    BC_JUMP     = 3'd0,
    BC_CALL     = 3'd1,
    BC_INDIRECT = 3'd2,
    BC_TRAP     = 3'd3,
    BC_LOOP     = 3'd4,
    BC_DECIDE   = 3'd5,
    BC_COND     = 3'd6,
    BC_RSVD     = 3'd7
  } br_class_e;

  typedef enum logic [MODE_W-1:0] {
    PM_BIAS_NT = 2'd0,
    PM_HINT    = 2'd1,
    PM_SIGN    = 2'd2,
    PM_DYN     = 2'd3
  } pol_mode_e;

  typedef struct packed {
    logic hint;
    logic disp_neg;
    logic dyn_ok;
    logic dyn_dir;
  } br_info_t;
endpackage

// File: rtl/bp_policy.sv
module bp_policy
  import bp_pkg::*;
(
  input  logic [CLS_W-1:0]  cls,
  input  logic [MODE_W-1:0] mode,
  input  br_info_t          info,
  output logic              taken
);
  logic cond_dir;

  // Policy for general conditional branches, picked by mode
  always_comb begin
    unique case (pol_mode_e'(mode))
      PM_BIAS_NT: cond_dir = 1'b0;
      PM_HINT:    cond_dir = info.hint;
      PM_SIGN:    cond_dir = info.disp_neg;
      PM_DYN:     cond_dir = info.dyn_ok & info.dyn_dir;
      default:    cond_dir = 1'b0;
    endcase
  end

  always_comb begin
    unique case (br_class_e'(cls))
      BC_JUMP, BC_CALL, BC_INDIRECT, BC_TRAP, BC_LOOP: taken = 1'b1;
      BC_DECIDE: taken = info.dyn_ok ? info.dyn_dir : cond_dir;
      BC_COND:   taken = cond_dir;
      default:   taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/bp_sat_counter.sv
module bp_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && count != TOP)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/brclass_pred.sv
module brclass_pred
  import bp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             req_valid,
  input  logic [2:0]       req_class,
  input  logic             req_hint,
  input  logic             req_disp_neg,
  input  logic             dyn_valid,
  input  logic             dyn_taken,
  output logic             pred_valid,
  output logic             pred_taken,
  input  logic             res_valid,
  input  logic             res_taken,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int NCNT = 2;

  br_info_t   info;
  logic       guess;
  logic [NCNT-1:0]  bump;
  logic [CNT_W-1:0] cnt [NCNT];

  assign info = '{hint: req_hint, disp_neg: req_disp_neg,
                  dyn_ok: dyn_valid, dyn_dir: dyn_taken};

  bp_policy u_policy (
    .cls   (req_class),
    .mode  (mode),
    .info  (info),
    .taken (guess)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
    end else begin
      pred_valid <= req_valid;
      if (req_valid)
        pred_taken <= guess;
    end
  end

  // index 0 counts hits, index 1 counts misses
  assign bump[0] = res_valid & (res_taken == pred_taken);
  assign bump[1] = res_valid & (res_taken != pred_taken);

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    bp_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (bump[g]),
      .count (cnt[g])
    );
  end

  assign hit_count  = cnt[0];
  assign miss_count = cnt[1];
endmodule

// File: rtl/brclass_pred_chk.sv
module brclass_pred_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [2:0]       req_class,
  input logic             pred_valid,
  input logic             pred_taken,
  input logic             res_valid,
  input logic             res_taken,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!pred_valid && !pred_taken && hit_count == '0 && miss_count == '0));

  p_always_taken_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_class <= 3'd4) |=> pred_taken);

  p_reserved_nt_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_class == 3'd7) |=> !pred_taken);

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> pred_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!pred_valid && $stable(pred_taken)));

  p_hit_step_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_taken == pred_taken && hit_count != TOP)
      |=> (hit_count == $past(hit_count) + 1'b1 && $stable(miss_count)));

  p_miss_step_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_taken != pred_taken && miss_count != TOP)
      |=> (miss_count == $past(miss_count) + 1'b1 && $stable(hit_count)));

  p_no_res_r10: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> ($stable(hit_count) && $stable(miss_count)));

  p_sat_r11: assert property (@(posedge clk) disable iff (rst)
    (hit_count == TOP) |=> (hit_count == TOP));

  p_sat_miss_r11: assert property (@(posedge clk) disable iff (rst)
    (miss_count == TOP) |=> (miss_count == TOP));
endmodule

bind brclass_pred brclass_pred_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_class  (req_class),
  .pred_valid (pred_valid),
  .pred_taken (pred_taken),
  .res_valid  (res_valid),
  .res_taken  (res_taken),
  .hit_count  (hit_count),
  .miss_count (miss_count)
);

// File: tb/sim_brclass_pred.sv
module sim_brclass_pred;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int WATCHDOG = 100000;
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = '0;
  logic req_valid = 1'b0;
  logic [2:0] req_class = '0;
  logic req_hint = 1'b0, req_disp_neg = 1'b0, dyn_valid = 1'b0, dyn_taken = 1'b0;
  logic res_valid = 1'b0, res_taken = 1'b0;
  logic pred_valid, pred_taken;
  logic [CW-1:0] hit_count, miss_count;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit ended = 0;

  logic e_valid, e_taken;
  logic [CW-1:0] e_hit, e_miss;
  string e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  brclass_pred #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid),
    .req_class(req_class), .req_hint(req_hint), .req_disp_neg(req_disp_neg),
    .dyn_valid(dyn_valid), .dyn_taken(dyn_taken), .pred_valid(pred_valid),
    .pred_taken(pred_taken), .res_valid(res_valid), .res_taken(res_taken),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic cond_rule(logic [1:0] m, logic h, logic n, logic dv, logic dt);
    case (m)
      2'd0: return 1'b0;
      2'd1: return h;
      2'd2: return n;
      default: return dv & dt;
    endcase
  endfunction

  function automatic logic model(logic [2:0] c, logic [1:0] m, logic h, logic n,
                                 logic dv, logic dt);
    if (c <= 3'd4) return 1'b1;
    if (c == 3'd5) return dv ? dt : cond_rule(m, h, n, dv, dt);
    if (c == 3'd6) return cond_rule(m, h, n, dv, dt);
    return 1'b0;
  endfunction

  function automatic string tag_of(logic [2:0] c, logic [1:0] m);
    if (c <= 3'd4) return "R2";
    if (c == 3'd5) return "R7";
    if (c == 3'd7) return "R8";
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven; advance model, clock, compare
  task automatic step();
    logic nt;
    nt = model(req_class, mode, req_hint, req_disp_neg, dyn_valid, dyn_taken);
    if (res_valid) begin
      if (res_taken == e_taken) begin if (e_hit != TOP) e_hit++; end
      else if (e_miss != TOP) e_miss++;
    end
    e_valid = req_valid;
    if (req_valid) begin e_taken = nt; e_tag = tag_of(req_class, mode); end
    @(posedge clk);
    @(negedge clk);
    check("R9 pred_valid", CW'(pred_valid), CW'(e_valid));
    check(req_valid ? e_tag : "R9 hold", CW'(pred_taken), CW'(e_taken));
    check("R10 hit", hit_count, e_hit);
    check("R10 miss", miss_count, e_miss);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 0; res_valid = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    e_valid = 0; e_taken = 0; e_hit = '0; e_miss = '0; e_tag = "R1";
    check("R1 pred_valid", CW'(pred_valid), '0);
    check("R1 pred_taken", CW'(pred_taken), '0);
    check("R1 hit", hit_count, '0);
    check("R1 miss", miss_count, '0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !ended) begin
      ended = 1;
      bad++; total++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // directed sweep: every class x mode x hint/sign/dyn pattern
    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 4; m++)
        for (int p = 0; p < 16; p++) begin
          req_valid = 1; req_class = 3'(c); mode = 2'(m);
          req_hint = p[0]; req_disp_neg = p[1]; dyn_valid = p[2]; dyn_taken = p[3];
          res_valid = 0;
          step();
        end

    // R9: idle cycles keep the held guess while other inputs wander
    req_valid = 1; req_class = 3'd0; step();
    req_valid = 0; req_class = 3'd7;
    for (int i = 0; i < 4; i++) step();

    // R11: saturate hits with matching outcomes (held guess is 0 after reset)
    do_reset();
    res_valid = 1; res_taken = 0;
    for (int i = 0; i < 3 * (1 << CW); i++) step();
    check("R11 hit saturated", hit_count, TOP);
    res_taken = 1;
    for (int i = 0; i < 3 * (1 << CW); i++) step();
    check("R11 miss saturated", miss_count, TOP);

    // random mix, resolve often overlapping requests
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0 && i != 0) do_reset();
      req_valid    = ($urandom_range(0, 3) != 0);
      req_class    = 3'($urandom_range(0, 7));
      mode         = 2'($urandom_range(0, 3));
      req_hint     = 1'($urandom_range(0, 1));
      req_disp_neg = 1'($urandom_range(0, 1));
      dyn_valid    = 1'($urandom_range(0, 1));
      dyn_taken    = 1'($urandom_range(0, 1));
      res_valid    = ($urandom_range(0, 2) == 0);
      res_taken    = 1'($urandom_range(0, 1));
      step();
    end

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule